// File: doc/BRIEF.md
# Configuration Image Streaming Loader

The loader takes a configuration image as a byte stream under a valid/ready handshake and delivers its payload, one byte per strobe, to the configuration port of a downstream target. Every image starts with a sixteen-byte header. Its first four bytes give the payload length, with the most significant byte first. The remaining twelve header bytes carry fields that this block does not interpret.

A load begins with a start strobe. The loader pulses the target reset and waits a programmable settle time. It then writes a single zero byte and waits the settle time again. After that it reads the header and forwards the payload. Any stream bytes that remain beyond the payload, up to the image size, are read and discarded. Five zero bytes follow the payload. The loader then samples the target's error line. If the line is clear, it waits a last settle time and reports done. If the line is set, it reports error.

Interrupt-style reporting is held off while a load runs and is enabled only after a clean finish. An image declared shorter than the header is refused at once.

Top module: `cfg_image_loader`

## Requirements
- R1: A start with an image size below 16 raises the error flag on the next cycle. Busy stays low, and no reset pulse and no port strobe are produced.
- R2: The payload length is taken from header bytes 0..3 as a big-endian 32-bit value. Byte 0 is bits 31:24.
- R3: The contents of header bytes 4..15 have no effect on anything written to the configuration port.
- R4: Payload bytes, starting at stream offset 16, are strobed out in stream order. There is exactly one strobe per byte, and the number of strobes equals the header length. A length of zero sends no payload.
- R5: After a start, the target reset is high for exactly one cycle. A strobe carrying 0x00 follows, settle+2 cycles after the reset cycle. The stream ready first rises settle+1 cycles after that zero strobe.
- R6: After the payload, exactly five strobes carrying 0x00 are written.
- R7: If the target error input is high after the five pad strobes, the load ends with the error flag set and the done flag clear.
- R8: If the target error input is low at that point, the loader waits a final settle time and then sets the done flag.
- R9: The interrupt enable output is low whenever busy is high. It goes high only together with done and stays low after an error.
- R10: Stream bytes after the payload, up to the image size, are accepted and never forwarded.
- R11: A start strobe while busy is ignored. The running load is not restarted, and its latched image size is kept.
- R12: Port strobes, stream ready and target reset occur only while busy is high.
- R13: Done and error are never high together. Both are cleared by the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start a load (single-cycle strobe) |
| image_size_i | input | 32 | Total image length in bytes, header included |
| settle_cycles_i | input | 16 | Settle delay count |
| in_valid_i | input | 1 | Stream byte valid |
| in_data_i | input | 8 | Stream byte |
| in_ready_o | output | 1 | Loader accepts the stream byte |
| cfg_strobe_o | output | 1 | Configuration port write strobe |
| cfg_data_o | output | 8 | Configuration port byte |
| tgt_reset_o | output | 1 | Target reset pulse |
| tgt_err_i | input | 1 | Configuration error reported by the target |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | Last load completed cleanly |
| error_o | output | 1 | Last load failed |
| irq_en_o | output | 1 | Interrupt reporting enabled |

## Verification
The bound checker watches, on every cycle, the invariants that relate the outputs to busy. These are: strobes, ready and reset appear only during a load; the reset pulse lasts one cycle; done and error are exclusive; the interrupt enable appears only with done and idle; a short image is refused at once; and a start during a load causes no second reset. The directed scenarios cover the properties that depend on the data and on cycle counts. They check the big-endian length decode, that header filler bytes have no effect, the order and count of payload bytes, the zero bytes before and after the payload, the exact settle gaps, the discarding of trailing bytes, and the outcome decided by the target error line.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

    localparam int HDR_BYTES = 16;
    localparam int LEN_BYTES = 4;
    localparam int PAD_BYTES = 5;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RST,
        ST_SET1,
        ST_SET2,
        ST_HDR,
        ST_PAY,
        ST_DRAIN,
        ST_PAD,
        ST_CHK,
        ST_SET3
    } ld_state_e;

    typedef struct packed {
        logic       strb;
        logic [7:0] data;
    } port_beat_t;

    function automatic logic too_short(input logic [31:0] sz);
        return sz < 32'(HDR_BYTES);
    endfunction

endpackage

// File: rtl/cfg_settle_timer.sv
module cfg_settle_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/cfg_hdr_capture.sv
module cfg_hdr_capture #(
    parameter int SIZE_W = 32,
    parameter int HDR_N  = 16,
    parameter int LEN_N  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              take,
    input  logic [7:0]        data,
    output logic [SIZE_W-1:0] len_o,
    output logic              last_o
);
    localparam int IDX_W = $clog2(HDR_N);

    logic [IDX_W-1:0]  idx_q;
    logic [SIZE_W-1:0] len_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            idx_q <= '0;
            len_q <= '0;
        end else if (take) begin
            idx_q <= idx_q + 1'b1;
            if (idx_q < IDX_W'(LEN_N)) begin
                len_q <= {len_q[SIZE_W-9:0], data};
            end
        end
    end

    assign len_o  = len_q;
    assign last_o = take && (idx_q == IDX_W'(HDR_N - 1));
endmodule

// File: rtl/cfg_image_loader.sv
module cfg_image_loader
    import cfg_loader_pkg::*;
#(
    parameter int SIZE_W = 32,
    parameter int SET_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [SIZE_W-1:0] image_size_i,
    input  logic [SET_W-1:0]  settle_cycles_i,
    input  logic              in_valid_i,
    input  logic [7:0]        in_data_i,
    output logic              in_ready_o,
    output logic              cfg_strobe_o,
    output logic [7:0]        cfg_data_o,
    output logic              tgt_reset_o,
    input  logic              tgt_err_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              error_o,
    output logic              irq_en_o
);
    localparam int PAD_W = $clog2(PAD_BYTES + 1);

    ld_state_e         st_q;
    logic [SIZE_W-1:0] size_q;
    logic [SIZE_W-1:0] taken_q;
    logic [SIZE_W-1:0] rem_q;
    logic [PAD_W-1:0]  pad_q;
    port_beat_t        beat_q;
    logic              done_q, err_q, irq_q;

    logic              accept;
    logic              tmr_load, tmr_exp;
    logic              hdr_take, hdr_last;
    logic [SIZE_W-1:0] hdr_len;

    always_comb begin
        unique case (st_q)
            ST_HDR, ST_PAY: in_ready_o = 1'b1;
            ST_DRAIN:       in_ready_o = (taken_q < size_q);
            default:        in_ready_o = 1'b0;
        endcase
    end

    assign accept   = in_valid_i && in_ready_o;
    assign hdr_take = accept && (st_q == ST_HDR);
    assign tmr_load = (st_q == ST_RST)
                   || (st_q == ST_SET1 && tmr_exp)
                   || (st_q == ST_CHK && !tgt_err_i);

    cfg_settle_timer #(.W(SET_W)) i_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (settle_cycles_i),
        .expired  (tmr_exp)
    );

    cfg_hdr_capture #(
        .SIZE_W (SIZE_W),
        .HDR_N  (HDR_BYTES),
        .LEN_N  (LEN_BYTES)
    ) i_hdr (
        .clk    (clk),
        .rst    (rst),
        .clear  (st_q == ST_IDLE),
        .take   (hdr_take),
        .data   (in_data_i),
        .len_o  (hdr_len),
        .last_o (hdr_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            size_q  <= '0;
            taken_q <= '0;
            rem_q   <= '0;
            pad_q   <= '0;
            beat_q  <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            beat_q <= '0;
            unique case (st_q)
                ST_IDLE: begin
                    if (start_i) begin
                        done_q <= 1'b0;
                        irq_q  <= 1'b0;
                        if (too_short(32'(image_size_i))) begin
                            err_q <= 1'b1;
                        end else begin
                            err_q   <= 1'b0;
                            size_q  <= image_size_i;
                            taken_q <= '0;
                            st_q    <= ST_RST;
                        end
                    end
                end
                ST_RST: st_q <= ST_SET1;
                ST_SET1: begin
                    if (tmr_exp) begin
                        beat_q <= '{strb: 1'b1, data: 8'h00};
                        st_q   <= ST_SET2;
                    end
                end
                ST_SET2: begin
                    if (tmr_exp) st_q <= ST_HDR;
                end
                ST_HDR: begin
                    if (accept) begin
                        taken_q <= taken_q + 1'b1;
                        if (hdr_last) begin
                            rem_q <= hdr_len;
                            st_q  <= (hdr_len == '0) ? ST_DRAIN : ST_PAY;
                        end
                    end
                end
                ST_PAY: begin
                    if (accept) begin
                        taken_q <= taken_q + 1'b1;
                        beat_q  <= '{strb: 1'b1, data: in_data_i};
                        rem_q   <= rem_q - 1'b1;
                        if (rem_q == SIZE_W'(1)) st_q <= ST_DRAIN;
                    end
                end
                ST_DRAIN: begin
                    if (accept) begin
                        taken_q <= taken_q + 1'b1;
                    end else if (!(taken_q < size_q)) begin
                        pad_q <= '0;
                        st_q  <= ST_PAD;
                    end
                end
                ST_PAD: begin
                    beat_q <= '{strb: 1'b1, data: 8'h00};
                    pad_q  <= pad_q + 1'b1;
                    if (pad_q == PAD_W'(PAD_BYTES - 1)) st_q <= ST_CHK;
                end
                ST_CHK: begin
                    if (tgt_err_i) begin
                        err_q <= 1'b1;
                        st_q  <= ST_IDLE;
                    end else begin
                        st_q <= ST_SET3;
                    end
                end
                ST_SET3: begin
                    if (tmr_exp) begin
                        done_q <= 1'b1;
                        irq_q  <= 1'b1;
                        st_q   <= ST_IDLE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign cfg_strobe_o = beat_q.strb;
    assign cfg_data_o   = beat_q.data;
    assign tgt_reset_o  = (st_q == ST_RST);
    assign busy_o       = (st_q != ST_IDLE);
    assign done_o       = done_q;
    assign error_o      = err_q;
    assign irq_en_o     = irq_q;
endmodule

// File: rtl/cfg_image_loader_chk.sv
module cfg_image_loader_chk #(
    parameter int SIZE_W = 32,
    parameter int SET_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic [SIZE_W-1:0] image_size_i,
    input logic [SET_W-1:0]  settle_cycles_i,
    input logic              in_valid_i,
    input logic [7:0]        in_data_i,
    input logic              in_ready_o,
    input logic              cfg_strobe_o,
    input logic [7:0]        cfg_data_o,
    input logic              tgt_reset_o,
    input logic              tgt_err_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              error_o,
    input logic              irq_en_o
);
    a_r12_strobe_in_busy: assert property (@(posedge clk) disable iff (rst)
        cfg_strobe_o |-> busy_o);

    a_r12_ready_in_busy: assert property (@(posedge clk) disable iff (rst)
        in_ready_o |-> busy_o);

    a_r5_reset_one_cycle: assert property (@(posedge clk) disable iff (rst)
        tgt_reset_o |=> !tgt_reset_o);

    a_r13_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(done_o && error_o));

    a_r9_irq_only_done: assert property (@(posedge clk) disable iff (rst)
        irq_en_o |-> (done_o && !busy_o));

    a_r1_short_refused: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && start_i && image_size_i < SIZE_W'(16)) |=> (error_o && !busy_o));

    a_r11_no_restart: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i) |=> !tgt_reset_o);
endmodule

bind cfg_image_loader cfg_image_loader_chk #(.SIZE_W(SIZE_W), .SET_W(SET_W)) i_chk (.*);

// File: tb/test_cfg_image_loader.sv
module test_cfg_image_loader;
    logic        clk = 1'b0;
    logic        rst;
    logic        start_i;
    logic [31:0] image_size_i;
    logic [15:0] settle_cycles_i;
    logic        in_valid_i;
    logic [7:0]  in_data_i;
    logic        in_ready_o;
    logic        cfg_strobe_o;
    logic [7:0]  cfg_data_o;
    logic        tgt_reset_o;
    logic        tgt_err_i;
    logic        busy_o, done_o, error_o, irq_en_o;

    always #10 clk = ~clk;

    cfg_image_loader i_cfg_image_loader (.*);

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int nstrb, nrst, r_cyc, s_cyc, rdy_cyc;
    bit irq_busy;
    logic [7:0] srec [0:511];
    logic [7:0] img  [0:511];

    always @(negedge clk) begin
        cyc++;
        if (cfg_strobe_o) begin
            if (nstrb == 0) s_cyc = cyc;
            if (nstrb < 512) srec[nstrb] = cfg_data_o;
            nstrb++;
        end
        if (tgt_reset_o) begin
            nrst++;
            r_cyc = cyc;
        end
        if (in_ready_o && rdy_cyc < 0) rdy_cyc = cyc;
        if (busy_o && irq_en_o) irq_busy = 1'b1;
    end

    task automatic mon_clr();
        nstrb = 0; nrst = 0; r_cyc = -1; s_cyc = -1; rdy_cyc = -1; irq_busy = 1'b0;
    endtask

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pay(input int i, input int seed);
        return 8'((i * 13 + seed) & 255);
    endfunction

    task automatic build(input int len, input int extra, input logic [7:0] fill, input int seed);
        img[0] = 8'(len >> 24); img[1] = 8'(len >> 16);
        img[2] = 8'(len >> 8);  img[3] = 8'(len);
        for (int i = 4; i < 16; i++) img[i] = fill ^ 8'(i);
        for (int i = 0; i < len; i++) img[16 + i] = pay(i, seed);
        for (int i = 0; i < extra; i++) img[16 + len + i] = 8'hEE;
    endtask

    task automatic push(input logic [7:0] b);
        in_valid_i = 1'b1;
        in_data_i  = b;
        while (!in_ready_o) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run_load(input int size, input int settle, input bit err);
        image_size_i    = 32'(size);
        settle_cycles_i = 16'(settle);
        tgt_err_i       = err;
        @(posedge clk);
        mon_clr();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        for (int i = 0; i < size; i++) push(img[i]);
        in_valid_i = 1'b0;
        while (busy_o) @(negedge clk);
    endtask

    task automatic check_stream(input int len, input int seed, input int settle);
        int mism = 0;
        chk(nstrb == len + 6, "R4 R6 strobe count", nstrb, len + 6);
        chk(srec[0] == 8'h00, "R5 dummy byte zero", srec[0], 0);
        for (int i = 0; i < len; i++) if (srec[1 + i] != pay(i, seed)) mism++;
        chk(mism == 0, "R4 payload order", mism, 0);
        mism = 0;
        for (int i = 0; i < 5; i++) if (srec[len + 1 + i] != 8'h00) mism++;
        chk(mism == 0, "R6 five zero pads", mism, 0);
        chk(nrst == 1, "R5 one reset pulse", nrst, 1);
        chk(s_cyc - r_cyc == settle + 2, "R5 reset to dummy gap", s_cyc - r_cyc, settle + 2);
        chk(rdy_cyc - s_cyc == settle + 1, "R5 dummy to ready gap", rdy_cyc - s_cyc, settle + 1);
    endtask

    task automatic t_reset_state();
        chk(!busy_o && !done_o && !error_o, "R13 reset flags", {busy_o, done_o, error_o}, 0);
        chk(!irq_en_o && !in_ready_o && !cfg_strobe_o, "R9 reset outputs",
            {irq_en_o, in_ready_o, cfg_strobe_o}, 0);
    endtask

    task automatic t_short();
        image_size_i = 32'd10;
        @(posedge clk);
        mon_clr();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        chk(error_o && !busy_o, "R1 short image error", {error_o, busy_o}, 2'b10);
        repeat (3) @(negedge clk);
        chk(nstrb == 0 && nrst == 0, "R1 nothing sent", nstrb + nrst, 0);
    endtask

    task automatic t_basic();
        build(3, 0, 8'h11, 7);
        run_load(19, 3, 1'b0);
        check_stream(3, 7, 3);
        chk(done_o && !error_o, "R8 done after clean load", {done_o, error_o}, 2'b10);
        chk(irq_en_o && !irq_busy, "R9 irq after done only", {irq_en_o, irq_busy}, 2'b10);
    endtask

    task automatic t_ignore_hdr();
        build(3, 0, 8'hC4, 7);
        run_load(19, 0, 1'b0);
        check_stream(3, 7, 0);
        chk(done_o, "R3 filler bytes ignored", done_o, 1);
    endtask

    task automatic t_bigendian();
        build(258, 0, 8'h00, 90);
        run_load(274, 1, 1'b0);
        check_stream(258, 90, 1);
        chk(done_o, "R2 big-endian length", done_o, 1);
    endtask

    task automatic t_zero_len();
        build(0, 0, 8'h55, 1);
        run_load(16, 2, 1'b0);
        check_stream(0, 1, 2);
        chk(done_o, "R4 zero length done", done_o, 1);
    endtask

    task automatic t_extra();
        build(4, 5, 8'h21, 3);
        run_load(25, 1, 1'b0);
        check_stream(4, 3, 1);
        chk(done_o && !in_ready_o, "R10 trailing bytes drained", {done_o, in_ready_o}, 2'b10);
    endtask

    task automatic t_target_err();
        build(2, 0, 8'h09, 5);
        run_load(18, 1, 1'b1);
        check_stream(2, 5, 1);
        chk(error_o && !done_o, "R7 target error reported", {error_o, done_o}, 2'b10);
        chk(!irq_en_o, "R9 irq off after error", irq_en_o, 0);
        tgt_err_i = 1'b0;
    endtask

    task automatic t_busy_start();
        build(3, 0, 8'h33, 11);
        image_size_i = 32'd19; settle_cycles_i = 16'd2; tgt_err_i = 1'b0;
        @(posedge clk);
        mon_clr();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        chk(!done_o, "R13 done cleared by start", done_o, 0);
        @(negedge clk); start_i = 1'b1; image_size_i = 32'd4;
        @(negedge clk); start_i = 1'b0;
        for (int i = 0; i < 19; i++) push(img[i]);
        in_valid_i = 1'b0;
        while (busy_o) @(negedge clk);
        chk(done_o && !error_o && nrst == 1, "R11 restart ignored",
            {done_o, error_o, 8'(nrst)}, {2'b10, 8'd1});
        chk(nstrb == 9, "R11 full stream kept", nstrb, 9);
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1; start_i = 1'b0; image_size_i = '0; settle_cycles_i = '0;
        in_valid_i = 1'b0; in_data_i = '0; tgt_err_i = 1'b0;
        mon_clr();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_short();
        t_basic();
        t_ignore_hdr();
        t_bigendian();
        t_zero_len();
        t_extra();
        t_target_err();
        t_busy_start();
        summary();
        $finish;
    end
endmodule